// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block is the digital sequencing side of a successive-approximation converter attached to a byte-wide register bus. Software programs a control register and a channel register. It starts a conversion by setting the enable and start bits together. The block then counts a fixed number of converter clock ticks and captures a 10-bit sample from an external sample port. It raises a completion flag and, when enabled, a level interrupt request.

Converter ticks are derived from a global cycle count that runs from reset. A tick falls on every system cycle whose count is an exact multiple of the prescaler divisor. In the alternate device variant, that divisor is further multiplied by twelve. Tick timing therefore depends on the absolute cycle number, not on the moment a conversion is started. Single-shot mode stops after one conversion. Free-running mode reloads the tick counter at each completion and keeps converting until software clears the enable bit.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all four bus registers read 0, irq is 0 and sample_ch is 0.
- R2: Bus address 0 is the control register, address 1 the channel register, address 2 the low data register and address 3 the high data register. Control bits are: 7 enable, 6 start, 5 free-run, 4 done flag, 3 interrupt enable, 2:0 prescaler select. Written enable, free-run, interrupt-enable and prescaler bits read back as written.
- R3: A conversion is armed only by one control write with bits 7 and 6 both 1. Arming loads 13 converter ticks. A write of start without enable stores start as 0 and arms nothing. Start also reads 0 after any write that leaves enable set but start clear.
- R4: A converter tick occurs in each cycle whose global cycle count, counted from 0 in the first cycle after reset, is a multiple of the divisor. Prescaler select 0 and 1 give a divisor of 2, and select n from 2 to 7 gives 2^n. A conversion completes at the end of its 13th tick after arming.
- R5: When alt_variant is 1, the divisor of R4 is multiplied by 12.
- R6: At completion, the done flag is set and the start bit cleared. sample_in is captured in that cycle only: bits 7:0 go to the low data register, and bits 9:8 go to bits 1:0 of the high data register, whose bits 7:2 read 0.
- R7: With free-run set, the tick count reloads to 13 at completion, and the next conversion completes 13 ticks later.
- R8: Every control write leaves the done flag at 0. Writing the flag bit as 1 clears it, and writing it as 0 stores the 0. The other written bits are stored as described in R2 and R3.
- R9: irq is high while enable, interrupt enable and done flag are all 1. A cycle with irq_ack high clears the flag.
- R10: The channel register stores the low 4 bits of a write, reads 0 in bits 7:4, and drives sample_ch.
- R11: Bus writes to the data registers have no effect.
- R12: A control write with enable 0 during a conversion aborts it. No completion follows, start reads 0 and the data registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_variant | input | 1 | Selects the extra divide-by-12 on the tick rate |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| sample_ch | output | 4 | Channel number presented to the converter |
| sample_in | input | 10 | Converted sample from the converter |
| irq | output | 1 | Level interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge, clears the done flag |

## Verification
The hardest case is proving that ticks line up with the absolute cycle count and not with the start write. This matters most in the alternate variant, where a divisor such as 1536 means the phase of the start write strongly affects the completion cycle. The bench keeps its own cycle count from reset and predicts the completion cycle as the 13th multiple of the divisor after the arming cycle. It sweeps all eight prescaler codes in both variants. The sample port is held at a wrong value except during the predicted completion cycle, so an early, late or repeated capture shows up in the data registers.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

   localparam int BUS_W = 8;
   localparam int PS_W  = 3;

   // Field order of this struct is the bit layout of the control register, MSB first.
   typedef struct packed {
      logic            en;
      logic            start;
      logic            frun;
      logic            flag;
      logic            ie;
      logic [PS_W-1:0] ps;
   } ctrl_t;

   typedef enum logic [1:0] {
      A_CTRL = 2'd0,
      A_CHAN = 2'd1,
      A_DLO  = 2'd2,
      A_DHI  = 2'd3
   } addr_e;

endpackage

// File: rtl/adcseq_tick.sv
module adcseq_tick #(
   parameter int ALT_POW2 = 4,
   parameter int ALT_ODD  = 3,
   parameter bit ALT_EN   = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       alt_variant,
   input  logic [adcseq_pkg::PS_W-1:0] ps,
   output logic                       tick
);
   localparam int MAXSH = (1 << adcseq_pkg::PS_W) - 1;
   localparam int ASH   = $clog2(ALT_POW2);
   localparam int PW    = MAXSH + ASH;
   localparam int SW    = $clog2(PW + 1);
   localparam logic [PW-1:0] ONE = PW'(1);

   // Global count modulo a power of two; the odd factor of the variant is tracked separately.
   logic [PW-1:0] pcnt;
   logic [SW-1:0] sh;
   logic [PW-1:0] mask;
   logic          alt_sel;
   logic          odd_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pcnt <= '0;
      else        pcnt <= pcnt + ONE;
   end

   always_comb begin
      sh = (ps <= adcseq_pkg::PS_W'(1)) ? SW'(1) : SW'(ps);
      if (alt_sel) sh = sh + SW'(ASH);
      mask = (ONE << sh) - ONE;
   end

   generate
      if ((ALT_POW2 < 1) || ((ALT_POW2 & (ALT_POW2 - 1)) != 0)) begin : g_bad_pow
         $error("ALT_POW2 must be a power of two");
      end
      if ((ALT_ODD < 1) || ((ALT_ODD % 2) == 0)) begin : g_bad_odd
         $error("ALT_ODD must be odd");
      end

      if (ALT_EN) begin : g_alt_sel
         assign alt_sel = alt_variant;
      end else begin : g_no_alt
         assign alt_sel = 1'b0;
      end

      if (ALT_EN && (ALT_ODD > 1)) begin : g_odd
         localparam int OW = $clog2(ALT_ODD);
         logic [OW-1:0] ocnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       ocnt <= '0;
            else if (ocnt == OW'(ALT_ODD - 1)) ocnt <= '0;
            else                              ocnt <= ocnt + OW'(1);
         end
         assign odd_ok = (ocnt == '0);
         AST_ODD_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ocnt < OW'(ALT_ODD)); // R5
      end else begin : g_no_odd
         assign odd_ok = 1'b1;
      end
   endgenerate

   assign tick = ((pcnt & mask) == '0) && (!alt_sel || odd_ok);

endmodule

// File: rtl/adcseq_conv_cnt.sv
module adcseq_conv_cnt #(
   parameter int CONV_TICKS = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic arm,
   input  logic abort,
   input  logic frun,
   output logic done
);
   localparam int CW = $clog2(CONV_TICKS + 1);

   generate
      if (CONV_TICKS < 1) begin : g_bad_ticks
         $error("CONV_TICKS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   // A register write in the same cycle takes priority over a completing tick.
   assign done = tick && (cnt == CW'(1)) && !arm && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (abort)                cnt <= '0;
      else if (arm)                  cnt <= CW'(CONV_TICKS);
      else if (tick && cnt != '0) begin
         if (cnt == CW'(1)) cnt <= frun ? CW'(CONV_TICKS) : '0;
         else               cnt <= cnt - CW'(1);
      end
   end

   AST_CNT_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(CONV_TICKS));           // R3
   AST_ARM_LOAD:   assert property (@(posedge clk) disable iff (!rst_n) arm |=> cnt == CW'(CONV_TICKS));    // R3
   AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n) abort |=> cnt == '0);              // R12
   AST_FRUN_LOAD:  assert property (@(posedge clk) disable iff (!rst_n) done && frun |=> cnt == CW'(CONV_TICKS)); // R7
   AST_ONE_SHOT:   assert property (@(posedge clk) disable iff (!rst_n) done && !frun |=> cnt == '0);      // R6

endmodule

// File: rtl/adcseq_regs.sv
module adcseq_regs
   import adcseq_pkg::*;
#(
   parameter int DATA_W = 10,
   parameter int CH_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr,
   input  logic              we,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   input  logic              done,
   input  logic              ack,
   input  logic [DATA_W-1:0] sample_in,
   output ctrl_t             ctrl,
   output logic [CH_W-1:0]   chan,
   output logic              arm,
   output logic              abort
);
   localparam int HI_W = DATA_W - BUS_W;

   generate
      if ((DATA_W <= BUS_W) || (DATA_W > 2 * BUS_W)) begin : g_bad_data
         $error("DATA_W must span two bus bytes");
      end
      if ((CH_W < 1) || (CH_W > BUS_W)) begin : g_bad_ch
         $error("CH_W must fit in one bus byte");
      end
   endgenerate

   ctrl_t            wr_val;
   logic             wr_ctrl;
   logic [BUS_W-1:0] dlo;
   logic [HI_W-1:0]  dhi;

   assign wr_val  = ctrl_t'(wdata);
   assign wr_ctrl = we && (addr == A_CTRL);
   assign arm     = wr_ctrl && wr_val.en && wr_val.start;
   assign abort   = wr_ctrl && !wr_val.en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         chan <= '0;
         dlo  <= '0;
         dhi  <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl       <= wr_val;
            ctrl.flag  <= 1'b0;
            ctrl.start <= arm;
         end else if (ack) begin
            ctrl.flag  <= 1'b0;
         end
         if (done) begin
            ctrl.flag  <= 1'b1;
            ctrl.start <= 1'b0;
            dlo        <= sample_in[BUS_W-1:0];
            dhi        <= sample_in[DATA_W-1:BUS_W];
         end
         if (we && (addr == A_CHAN)) chan <= wdata[CH_W-1:0];
      end
   end

   always_comb begin
      case (addr)
         A_CTRL:  rdata = ctrl;
         A_CHAN:  rdata = BUS_W'(chan);
         A_DLO:   rdata = dlo;
         default: rdata = BUS_W'(dhi);
      endcase
   end

   AST_DONE_FLAG:  assert property (@(posedge clk) disable iff (!rst_n) done |=> ctrl.flag);               // R6
   AST_DONE_START: assert property (@(posedge clk) disable iff (!rst_n) done |=> !ctrl.start);             // R6
   AST_WR_FLAG:    assert property (@(posedge clk) disable iff (!rst_n) wr_ctrl && !done |=> !ctrl.flag);  // R8
   AST_ACK_CLEAR:  assert property (@(posedge clk) disable iff (!rst_n) ack && !done |=> !ctrl.flag);      // R9
   AST_DATA_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !done |=> $stable(dlo) && $stable(dhi)); // R11
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) abort |=> !ctrl.start && !ctrl.en); // R12

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adcseq_pkg::*;
#(
   parameter int DATA_W     = 10,
   parameter int CH_W       = 4,
   parameter int CONV_TICKS = 13,
   parameter int ALT_POW2   = 4,
   parameter int ALT_ODD    = 3,
   parameter bit ALT_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alt_variant,
   input  logic [1:0]        bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [CH_W-1:0]   sample_ch,
   input  logic [DATA_W-1:0] sample_in,
   output logic              irq,
   input  logic              irq_ack
);
   ctrl_t ctrl;
   logic  tick;
   logic  arm;
   logic  abort;
   logic  done;

   adcseq_tick #(
      .ALT_POW2 (ALT_POW2),
      .ALT_ODD  (ALT_ODD),
      .ALT_EN   (ALT_EN)
   ) u_tick (
      .clk         (clk),
      .rst_n       (rst_n),
      .alt_variant (alt_variant),
      .ps          (ctrl.ps),
      .tick        (tick)
   );

   adcseq_conv_cnt #(
      .CONV_TICKS (CONV_TICKS)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .arm   (arm),
      .abort (abort),
      .frun  (ctrl.frun),
      .done  (done)
   );

   adcseq_regs #(
      .DATA_W (DATA_W),
      .CH_W   (CH_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (bus_addr),
      .we        (bus_we),
      .wdata     (bus_wdata),
      .rdata     (bus_rdata),
      .done      (done),
      .ack       (irq_ack),
      .sample_in (sample_in),
      .ctrl      (ctrl),
      .chan      (sample_ch),
      .arm       (arm),
      .abort     (abort)
   );

   assign irq = ctrl.en && ctrl.ie && ctrl.flag;

   AST_IRQ_ACKED: assert property (@(posedge clk) disable iff (!rst_n) irq && irq_ack && !done |=> !irq); // R9

endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
   localparam int CT = 13;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       alt_variant = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'd0;
   logic [9:0] sample_in = 10'd0;
   logic       irq_ack = 1'b0;
   wire  [7:0] bus_rdata;
   wire  [3:0] sample_ch;
   wire        irq;

   int n_chk = 0;
   int n_err = 0;
   int tb_cyc;
   int wcyc;
   bit finished = 1'b0;

   adc_seq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .alt_variant(alt_variant),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .sample_ch(sample_ch), .sample_in(sample_in),
      .irq(irq), .irq_ack(irq_ack)
   );

   always #2 clk = ~clk;

   // Global cycle number as defined by R4: 0 in the first cycle after reset.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) tb_cyc <= 0;
      else        tb_cyc <= tb_cyc + 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wcyc      = tb_cyc;
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      bus_addr = a;
      #0.2;
      v = int'(bus_rdata);
   endtask

   function automatic int pdiv(input int ps, input bit alt);
      int d;
      d = (ps <= 1) ? 2 : (1 << ps);
      return alt ? d * 12 : d;
   endfunction

   function automatic int kdone(input int w, input int p);
      return ((w / p) + 1) * p + (CT - 1) * p;
   endfunction

   task automatic wait_to(input int k);
      @(negedge clk);
      while (tb_cyc != k) @(negedge clk);
   endtask

   task automatic conv(input string req, input int ps, input bit alt, input int ch,
                       input int smp, input bit ie);
      int p;
      int k;
      int v;
      alt_variant = alt;
      wr(2'd1, 8'(ch | 8'hA0));
      sample_in = 10'(~smp);
      wr(2'd0, 8'(8'hC0 | (int'(ie) << 3) | ps));
      p = pdiv(ps, alt);
      k = kdone(wcyc, p);
      wait_to(k);
      rd(2'd0, v);
      chk({req, " flag still clear in last tick cycle"}, (v >> 4) & 1, 0);
      chk("R10 sample_ch", int'(sample_ch), ch & 15);
      if (ie) chk("R9 irq low before completion", int'(irq), 0);
      sample_in = 10'(smp);
      @(negedge clk);
      sample_in = 10'(~smp);
      rd(2'd0, v);
      chk({req, " R6 ctrl after completion"}, v, 8'h90 | (int'(ie) << 3) | ps);
      rd(2'd2, v);
      chk("R6 low data", v, smp & 255);
      rd(2'd3, v);
      chk("R6 high data", v, (smp >> 8) & 3);
      if (ie) chk("R9 irq high after completion", int'(irq), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int v;
      int k1;
      int k2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(2'd0, v); chk("R1 ctrl", v, 0);
      rd(2'd1, v); chk("R1 chan", v, 0);
      rd(2'd2, v); chk("R1 low data", v, 0);
      rd(2'd3, v); chk("R1 high data", v, 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 sample_ch", int'(sample_ch), 0);

      // R4 / R5 sweep of every prescaler code in both variants
      for (int alt = 0; alt < 2; alt++) begin
         for (int ps = 0; ps < 8; ps++) begin
            conv(alt ? "R5" : "R4", ps, bit'(alt), (ps * 5 + alt * 3) & 15,
                 (ps * 97 + alt * 301 + 13) & 1023, 1'b0);
         end
      end
      alt_variant = 1'b0;

      // R8 writing flag as 1 clears it
      wr(2'd0, 8'h93);
      rd(2'd0, v); chk("R8 flag written 1", v, 8'h83);
      conv("R4", 1, 1'b0, 3, 10'h1C3, 1'b0);
      wr(2'd0, 8'h8A);
      rd(2'd0, v); chk("R8 flag written 0", v, 8'h8A);

      // R9 interrupt and acknowledge
      conv("R4", 1, 1'b0, 9, 10'h2A5, 1'b1);
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      chk("R9 irq after ack", int'(irq), 0);
      rd(2'd0, v); chk("R9 flag after ack", v, 8'h89);

      // R7 free-running: two back-to-back completions
      wr(2'd0, 8'hE2);
      k1 = kdone(wcyc, 4);
      k2 = k1 + CT * 4;
      sample_in = 10'h000;
      wait_to(k1);
      sample_in = 10'h155;
      @(negedge clk);
      sample_in = 10'h000;
      rd(2'd0, v); chk("R7 ctrl first", v, 8'hB2);
      rd(2'd2, v); chk("R7 low first", v, 8'h55);
      rd(2'd3, v); chk("R7 high first", v, 1);
      wait_to(k2);
      rd(2'd2, v); chk("R7 low before second", v, 8'h55);
      sample_in = 10'h2AA;
      @(negedge clk);
      sample_in = 10'h000;
      rd(2'd2, v); chk("R7 low second", v, 8'hAA);
      rd(2'd3, v); chk("R7 high second", v, 2);
      wr(2'd0, 8'h00);
      rd(2'd0, v); chk("R12 free-run stopped", v, 0);

      // R12 abort mid-conversion
      sample_in = 10'h3FF;
      wr(2'd0, 8'hC7);
      repeat (300) @(negedge clk);
      wr(2'd0, 8'h07);
      repeat (CT * 128 + 20) @(negedge clk);
      rd(2'd0, v); chk("R12 ctrl after abort", v, 8'h07);
      rd(2'd2, v); chk("R12 low kept", v, 8'hAA);
      rd(2'd3, v); chk("R12 high kept", v, 2);

      // R3 arming needs both bits
      wr(2'd0, 8'h40);
      rd(2'd0, v); chk("R3 start without enable", v, 0);
      wr(2'd0, 8'h80);
      repeat (60) @(negedge clk);
      rd(2'd0, v); chk("R3 enable alone", v, 8'h80);
      rd(2'd2, v); chk("R3 no capture", v, 8'hAA);

      // R2 field layout
      wr(2'd0, 8'hBD);
      rd(2'd0, v); chk("R2 layout", v, 8'hAD);
      chk("R9 no irq without flag", int'(irq), 0);
      wr(2'd0, 8'h00);

      // R10 channel register
      wr(2'd1, 8'hF6);
      rd(2'd1, v); chk("R10 chan read", v, 8'h06);
      chk("R10 sample_ch", int'(sample_ch), 6);

      // R11 data registers ignore writes
      wr(2'd2, 8'h5A);
      wr(2'd3, 8'hFF);
      @(negedge clk);
      rd(2'd2, v); chk("R11 low", v, 8'hAA);
      rd(2'd3, v); chk("R11 high", v, 2);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule